// File: doc/BRIEF.md
# Eight-Point Type-IV Cosine Transform Engine

This block turns a stream of signed fixed-point samples into eight-point type-IV cosine transform coefficients. It runs on a 16-cycle schedule. The samples of one block arrive one per cycle in a fixed shuffled slot order. A start pulse marks slot zero. If the continue input is high near the end of a block, the next block follows with no gap and needs no new start pulse.

Each block produces eight coefficients, one every second cycle, in a fixed permuted order. Every coefficient comes with its index. A lead strobe warns of the first coefficient two cycles ahead, and a next strobe precedes every coefficient by one cycle. The sum of products uses 18-bit signed cosine constants with 17 fractional bits. The result is right-shifted by a parameter; with a shift of three or more it cannot overflow the output.

The engine has two sample banks. One bank captures the current block while the other holds the previous block for output. As a result, a block's coefficients come out while the next block is streaming in.

Top module: `dct4_engine`

## Requirements
- R1: A synchronous reset clears all run state. In the cycle after reset is released, `y_vld`, `y_next` and `y_lead` are all low, and they stay low until a start pulse is accepted.
- R2: Phase p of a block is the p-th cycle counted from slot zero. Sample X[n] is taken from this slot: X2 at phase 0, X7 at 1, X3 at 2, X4 at 3, X5 at 4, X6 at 5, X0 at 6, X1 at 7. Values presented in phases 8 to 15 are ignored.
- R3: Coefficient k equals floor(sum over n of X[n]*C(n,k) / 2^(17+SHIFT)). C(n,k) is round(2^17*cos(pi*(2n+1)*(2k+1)/32)). The result stays within 2 + sum|X|/2^21 LSB of the exact real value.
- R4: Within a block the coefficients appear in the order k = 0, 7, 4, 3, 1, 6, 2, 5, spaced two cycles apart. `y_k` carries k while `y_vld` is high.
- R5: If the start pulse is sampled in cycle s, the j-th coefficient of that block is valid in cycle s+17+2j.
- R6: `y_next` is high in exactly the cycles that precede a cycle with `y_vld` high.
- R7: `y_lead` is high for one cycle, two cycles before the first coefficient (k=0) of each block.
- R8: If `keep_going` is high at phase 14, the next block begins at the following phase-0 cycle with no start pulse. If it is low, the engine goes idle after phase 15 and produces no further coefficients.
- R9: A start pulse that arrives while a block is being received has no effect.
- R10: With SHIFT=3, full-scale inputs of either sign give correct coefficients, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Marks slot zero of a new block when idle |
| keep_going | input | 1 | Sampled at phase 14; continues with the next block |
| x_in | input | W_IN | Signed sample for the current slot |
| y_lead | output | 1 | Two cycles ahead of a block's first coefficient |
| y_next | output | 1 | One cycle ahead of each coefficient |
| y_vld | output | 1 | Coefficient valid on `y` |
| y | output | W_OUT | Signed coefficient |
| y_k | output | 3 | Index k of the coefficient on `y` |

## Verification
The bench uses the default build: 24-bit input and output, and a shift of three. This makes full-scale samples of 2^23-1 and -2^23 reachable, so the no-overflow claim is tested at its actual limit. It also makes the cosine rounding error visible against a real-valued reference. The bench fills the ignored slots with random values and runs a three-block chain with a stray start pulse in the middle block. These runs cover slot mapping, continuation and the ignored start in a single timeline.

// File: rtl/dct4_engine.sv
module dct4_engine #(
  parameter int W_IN  = 24,
  parameter int W_OUT = 24,
  parameter int SHIFT = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    keep_going,
  input  logic signed [W_IN-1:0]  x_in,
  output logic                    y_lead,
  output logic                    y_next,
  output logic                    y_vld,
  output logic signed [W_OUT-1:0] y,
  output logic [2:0]              y_k
);
  // cosine table below is scaled for 17 fractional bits
  localparam int CF = 17;
  localparam int CW = CF + 1;
  localparam int PW = W_IN + CW;
  localparam int AW = PW + 3 + W_OUT + SHIFT;

  function automatic logic [2:0] slot_of(input logic [2:0] p);
    case (p)
      3'd0: return 3'd2;
      3'd1: return 3'd7;
      3'd2: return 3'd3;
      3'd3: return 3'd4;
      3'd4: return 3'd5;
      3'd5: return 3'd6;
      3'd6: return 3'd0;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [2:0] k_of(input logic [2:0] j);
    case (j)
      3'd0: return 3'd0;
      3'd1: return 3'd7;
      3'd2: return 3'd4;
      3'd3: return 3'd3;
      3'd4: return 3'd1;
      3'd5: return 3'd6;
      3'd6: return 3'd2;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic signed [CW-1:0] cos_q(input int n, input int k);
    int m;
    logic neg;
    logic signed [CW-1:0] v;
    m = ((2*n + 1) * (2*k + 1)) % 64;
    if (m > 32) m = 64 - m;
    neg = (m > 16);
    if (neg) m = 32 - m;
    case (m)
      1:  v = CW'(130441);
      3:  v = CW'(125428);
      5:  v = CW'(115595);
      7:  v = CW'(101320);
      9:  v = CW'(83151);
      11: v = CW'(61787);
      13: v = CW'(38048);
      15: v = CW'(12847);
      default: v = '0;
    endcase
    return neg ? -v : v;
  endfunction

  logic                   in_run, cont, out_run;
  logic [3:0]             in_ph, out_ph;
  logic signed [W_IN-1:0] cap  [8];
  logic signed [W_IN-1:0] hold [8];
  logic signed [CW-1:0]   cq   [8];
  logic signed [PW-1:0]   prod [8];
  logic signed [AW-1:0]   acc;

  wire [3:0] cur_ph  = in_run ? in_ph : 4'd0;
  wire       accept  = in_run | start;
  wire       blk_end = in_run && (in_ph == 4'd15);
  wire [2:0] k_cur   = k_of(out_ph[3:1]);

  assign y_next = out_run && !out_ph[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_run  <= 1'b0;
      in_ph   <= '0;
      cont    <= 1'b0;
      out_run <= 1'b0;
      out_ph  <= '0;
      y_vld   <= 1'b0;
      y_lead  <= 1'b0;
    end else begin
      if (!in_run && start) begin
        in_run <= 1'b1;
        in_ph  <= 4'd1;
      end else if (in_run) begin
        in_ph <= in_ph + 4'd1;
        if (in_ph == 4'd15 && !cont) in_run <= 1'b0;
      end
      if (in_run && in_ph == 4'd14) cont <= keep_going;
      y_lead <= in_run && (in_ph == 4'd14);
      if (blk_end) begin
        out_run <= 1'b1;
        out_ph  <= '0;
      end else if (out_run) begin
        out_ph <= out_ph + 4'd1;
        if (out_ph == 4'd15) out_run <= 1'b0;
      end
      y_vld <= y_next;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !cur_ph[3]) cap[slot_of(cur_ph[2:0])] <= x_in;
    if (blk_end)
      for (int i = 0; i < 8; i++) hold[i] <= cap[i];
    if (y_next) begin
      y   <= W_OUT'(acc >>> (CF + SHIFT));
      y_k <= k_cur;
    end
  end

  for (genvar n = 0; n < 8; n++) begin : g_tap
    assign cq[n]   = cos_q(n, int'(k_cur));
    assign prod[n] = PW'(hold[n]) * PW'(cq[n]);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < 8; i++) acc = acc + AW'(prod[i]);
  end
endmodule

// File: rtl/dct4_engine_chk.sv
module dct4_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       y_lead,
  input logic       y_next,
  input logic       y_vld,
  input logic [2:0] y_k
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!y_vld && !y_lead)); // R1
  AST_VLD_SPACED:  assert property (@(posedge clk) disable iff (rst) y_vld |=> !y_vld); // R4
  AST_ORDER_HEAD:  assert property (@(posedge clk) disable iff (rst)
                     (y_vld && y_k == 3'd0) |-> ##2 (y_vld && y_k == 3'd7)); // R4
  AST_NEXT_LEADS:  assert property (@(posedge clk) disable iff (rst) y_next |=> y_vld); // R6
  AST_LEAD_TWO:    assert property (@(posedge clk) disable iff (rst)
                     y_lead |-> ##2 (y_vld && y_k == 3'd0)); // R7
endmodule

bind dct4_engine dct4_engine_chk u_chk (
  .clk(clk), .rst(rst), .y_lead(y_lead), .y_next(y_next), .y_vld(y_vld), .y_k(y_k)
);

// File: tb/dct4_engine_test.sv
module dct4_engine_test;
  localparam int W  = 24;
  localparam int NC = 2048;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, keep_going = 1'b0;
  logic signed [W-1:0] x_in = '0;
  logic y_lead, y_next, y_vld;
  logic signed [W-1:0] y;
  logic [2:0] y_k;

  dct4_engine uut (.clk(clk), .rst(rst), .start(start), .keep_going(keep_going),
                   .x_in(x_in), .y_lead(y_lead), .y_next(y_next), .y_vld(y_vld),
                   .y(y), .y_k(y_k));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  bit checking = 0, done = 0;
  bit  e_vld [NC];
  bit  e_lead[NC];
  int  e_k   [NC];
  real e_v   [NC];
  real e_tol [NC];
  string e_tag[NC];

  function automatic int slot_sample(input int p);
    int t[8] = '{2, 7, 3, 4, 5, 6, 0, 1};
    return t[p];
  endfunction

  function automatic int k_at(input int j);
    int t[8] = '{0, 7, 4, 3, 1, 6, 2, 5};
    return t[j];
  endfunction

  task automatic run_block(input int xs[8], input bit with_start, input bit keep,
                           input bit poke, input string tag);
    int s;
    real sabs;
    sabs = 0.0;
    for (int n = 0; n < 8; n++) sabs += (xs[n] < 0) ? -xs[n] : xs[n];
    for (int p = 0; p < 16; p++) begin
      @(posedge clk); #1;
      if (p == 0) s = cyc;
      start = (with_start && p == 0) || (poke && p == 5);
      keep_going = keep;
      x_in = (p < 8) ? W'(xs[slot_sample(p)]) : W'($urandom);
    end
    e_lead[s + 15] = 1'b1;
    for (int j = 0; j < 8; j++) begin
      real r;
      int k;
      k = k_at(j);
      r = 0.0;
      for (int n = 0; n < 8; n++)
        r += xs[n] * $cos(PI * (2*n + 1) * (2*k + 1) / 32.0);
      e_vld[s + 17 + 2*j] = 1'b1;
      e_k  [s + 17 + 2*j] = k;
      e_v  [s + 17 + 2*j] = r / 8.0;
      e_tol[s + 17 + 2*j] = 2.0 + sabs / 2097152.0;
      e_tag[s + 17 + 2*j] = tag;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      start = 1'b0; keep_going = 1'b0; x_in = W'($urandom);
    end
  endtask

  always @(negedge clk) begin
    if (checking && cyc < NC - 1) begin
      tests++;
      if (y_vld !== e_vld[cyc]) begin
        fails++;
        $display("FAIL R5 R8 y_vld cyc %0d got %0b exp %0b", cyc, y_vld, e_vld[cyc]);
      end
      tests++;
      if (y_next !== e_vld[cyc + 1]) begin
        fails++;
        $display("FAIL R6 y_next cyc %0d got %0b exp %0b", cyc, y_next, e_vld[cyc + 1]);
      end
      tests++;
      if (y_lead !== e_lead[cyc]) begin
        fails++;
        $display("FAIL R7 y_lead cyc %0d got %0b exp %0b", cyc, y_lead, e_lead[cyc]);
      end
      if (e_vld[cyc] && y_vld === 1'b1) begin
        real d;
        tests++;
        if (y_k !== 3'(e_k[cyc])) begin
          fails++;
          $display("FAIL R4 y_k cyc %0d got %0d exp %0d", cyc, y_k, e_k[cyc]);
        end
        tests++;
        d = $itor(y) - e_v[cyc];
        if (d < 0.0) d = -d;
        if (d > e_tol[cyc]) begin
          fails++;
          $display("FAIL %s R3 y k=%0d got %0d exp %f", e_tag[cyc], e_k[cyc], y, e_v[cyc]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int xs[8];
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    tests++;
    if (y_vld !== 1'b0 || y_next !== 1'b0 || y_lead !== 1'b0) begin
      fails++;
      $display("FAIL R1 strobes after reset got %0b%0b%0b exp 000", y_vld, y_next, y_lead);
    end
    checking = 1;
    idle(4);

    xs = '{default: 0}; xs[0] = 1 << 20;
    run_block(xs, 1, 0, 0, "R3");
    idle(30);

    xs = '{default: 0}; xs[5] = -(1 << 22);
    run_block(xs, 1, 0, 0, "R2");
    idle(30);

    for (int n = 0; n < 8; n++) xs[n] = $signed($urandom) >>> 8;
    run_block(xs, 1, 1, 0, "R2");
    for (int n = 0; n < 8; n++) xs[n] = $signed($urandom) >>> 8;
    run_block(xs, 0, 1, 1, "R9");
    for (int n = 0; n < 8; n++) xs[n] = $signed($urandom) >>> 8;
    run_block(xs, 0, 0, 0, "R8");
    idle(40);

    xs = '{default: (1 << 23) - 1};
    run_block(xs, 1, 0, 0, "R10");
    idle(30);

    for (int n = 0; n < 8; n++)
      xs[n] = ($cos(PI * (2*n + 1) / 32.0) < 0.0) ? (1 << 23) - 1 : -(1 << 23);
    run_block(xs, 1, 0, 0, "R10");
    idle(40);

    checking = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule